// File: doc/BRIEF.md
# PHY Reset and Receive-PLL Lock Sequencer

This block brings a serial PHY back to a known state after power-up or resume. A single start pulse launches a fixed command sequence on the PHY's control-register bus, through an external handshake master. First it selects the PHY's clock/reset register and writes its reset bit. The master sends this write without waiting for an acknowledge, because a PHY in reset cannot give one. The sequencer then runs a bounded poll loop. Each pass waits a programmable number of cycles, selects the lane status register, reads it and tests the receive-PLL state bit.

The sequence ends with a one-cycle done pulse, a pass flag and a two-bit error code. A bus error reported on any command ends the sequence at once. A poll loop that runs out of passes before the PLL reports stable ends the sequence with a PLL timeout. Each command is presented as a level, held steady until the master returns a response.

Top module: `phy_rst_seq`

## Requirements
- R1: After a start pulse is accepted in idle, the first command is an address command (op code 0) carrying 0x7F3F.
- R2: The second command is a write command (op code 1) carrying 0x0001, with bit 0 being the PHY reset bit.
- R3: Before every status poll, including the first, the sequencer issues no command for exactly DELAY_CYC cycles.
- R4: Each poll pass is an address command carrying 0x2003 followed by a read command (op code 2).
- R5: A read whose data has bit 1 set ends the sequence with pass_o=1 and err_o=0 (none).
- R6: After MAX_POLLS reads with bit 1 clear, the sequence ends with pass_o=0 and err_o=2 (PLL timeout), and no further read is issued.
- R7: A response with rsp_err_i=1 to any command ends the sequence in the next cycle with err_o=1 (bus error) and pass_o=0, and no further command follows.
- R8: done_o is a one-cycle pulse per sequence. pass_o and err_o hold their result until the next accepted start, which clears them to 0.
- R9: A start pulse that arrives while busy_o is high is ignored and produces no second sequence or done pulse.
- R10: While cmd_valid_o is high and no response has arrived, cmd_op_o and cmd_wdata_o stay stable.
- R11: After reset, busy_o, cmd_valid_o, done_o and pass_o are 0, and err_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse (power-up or resume) |
| busy_o | output | 1 | Sequence in progress |
| cmd_valid_o | output | 1 | Command request to the bus master, held until a response arrives |
| cmd_op_o | output | 2 | Command: 0 address, 1 write, 2 read |
| cmd_wdata_o | output | 16 | Address or write data for the command |
| rsp_valid_i | input | 1 | One-cycle response from the master |
| rsp_err_i | input | 1 | Response carries a bus error |
| rsp_rdata_i | input | 16 | Read data returned with a read response |
| done_o | output | 1 | One-cycle end-of-sequence pulse |
| pass_o | output | 1 | Receive PLL reported stable |
| err_o | output | 2 | 0 none, 1 bus error, 2 PLL timeout |

## Verification
The assertions check on every cycle that commands hold steady until answered, that done is a single-cycle pulse whose pass flag agrees with the error code, that a bus error ends the run on the next cycle, and that the read count never exceeds the poll limit. The exact command order and values, the length of each quiet delay window, the pass on the first or last allowed poll, and the ignoring of a start pulse during a run can only be shown by the bench's scenarios. The bench's bus and PHY model varies response latency, lock position and the command that fails.

// File: rtl/phy_rst_seq_pkg.sv
package phy_rst_seq_pkg;
  typedef enum logic [1:0] {
    OP_ADDR  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } cr_op_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_BUS  = 2'd1,
    ERR_PLL  = 2'd2
  } seq_err_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADR_RST,
    ST_WR_RST,
    ST_DELAY,
    ST_ADR_STAT,
    ST_RD_STAT,
    ST_FIN
  } seq_state_e;
endpackage

// File: rtl/phy_rst_seq_timer.sv
module phy_rst_seq_timer #(
  parameter int DELAY_CYC = 20
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic expire_o
);
  localparam int TW = (DELAY_CYC < 2) ? 1 : $clog2(DELAY_CYC);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == TW'(DELAY_CYC - 1));
endmodule

// File: rtl/phy_rst_seq_pollcnt.sv
module phy_rst_seq_pollcnt #(
  parameter int MAX_POLLS = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int PW = (MAX_POLLS < 2) ? 1 : $clog2(MAX_POLLS);

  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (inc_i) cnt_q <= cnt_q + 1'b1;
  end

  assign last_o = (cnt_q == PW'(MAX_POLLS - 1));
endmodule

// File: rtl/phy_rst_seq_fsm.sv
module phy_rst_seq_fsm
  import phy_rst_seq_pkg::*;
#(
  parameter int          DW        = 16,
  parameter logic [15:0] RST_REG   = 16'h7F3F,
  parameter logic [15:0] RST_VAL   = 16'h0001,
  parameter logic [15:0] STAT_REG  = 16'h2003,
  parameter logic [15:0] LOCK_MASK = 16'h0002
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          rsp_valid_i,
  input  logic          rsp_err_i,
  input  logic [DW-1:0] rsp_rdata_i,
  input  logic          dly_expire_i,
  input  logic          poll_last_i,
  output logic          dly_run_o,
  output logic          poll_clr_o,
  output logic          poll_inc_o,
  output logic          busy_o,
  output logic          cmd_valid_o,
  output cr_op_e        cmd_op_o,
  output logic [DW-1:0] cmd_wdata_o,
  output logic          done_o,
  output logic          pass_o,
  output seq_err_e      err_o
);
  seq_state_e state_q, state_d;
  logic       pass_q, pass_d;
  seq_err_e   err_q, err_d;
  logic       locked;

  // reduce over all bits so every data bit is consumed
  assign locked = |(rsp_rdata_i & DW'(LOCK_MASK));

  always_comb begin
    state_d     = state_q;
    pass_d      = pass_q;
    err_d       = err_q;
    cmd_valid_o = 1'b0;
    cmd_op_o    = OP_ADDR;
    cmd_wdata_o = '0;
    dly_run_o   = 1'b0;
    poll_clr_o  = 1'b0;
    poll_inc_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        poll_clr_o = 1'b1;
        if (start_i) begin
          state_d = ST_ADR_RST;
          pass_d  = 1'b0;
          err_d   = ERR_NONE;
        end
      end
      ST_ADR_RST: begin
        cmd_valid_o = 1'b1;
        cmd_wdata_o = DW'(RST_REG);
        if (rsp_valid_i) begin
          if (rsp_err_i) begin state_d = ST_FIN; err_d = ERR_BUS; end
          else state_d = ST_WR_RST;
        end
      end
      ST_WR_RST: begin
        cmd_valid_o = 1'b1;
        cmd_op_o    = OP_WRITE;
        cmd_wdata_o = DW'(RST_VAL);
        if (rsp_valid_i) begin
          if (rsp_err_i) begin state_d = ST_FIN; err_d = ERR_BUS; end
          else state_d = ST_DELAY;
        end
      end
      ST_DELAY: begin
        dly_run_o = 1'b1;
        if (dly_expire_i) state_d = ST_ADR_STAT;
      end
      ST_ADR_STAT: begin
        cmd_valid_o = 1'b1;
        cmd_wdata_o = DW'(STAT_REG);
        if (rsp_valid_i) begin
          if (rsp_err_i) begin state_d = ST_FIN; err_d = ERR_BUS; end
          else state_d = ST_RD_STAT;
        end
      end
      ST_RD_STAT: begin
        cmd_valid_o = 1'b1;
        cmd_op_o    = OP_READ;
        if (rsp_valid_i) begin
          if (rsp_err_i) begin
            state_d = ST_FIN; err_d = ERR_BUS;
          end else if (locked) begin
            state_d = ST_FIN; pass_d = 1'b1;
          end else if (poll_last_i) begin
            state_d = ST_FIN; err_d = ERR_PLL;
          end else begin
            state_d    = ST_DELAY;
            poll_inc_o = 1'b1;
          end
        end
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pass_q  <= 1'b0;
      err_q   <= ERR_NONE;
    end else begin
      state_q <= state_d;
      pass_q  <= pass_d;
      err_q   <= err_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_FIN);
  assign pass_o = pass_q;
  assign err_o  = err_q;
endmodule

// File: rtl/phy_rst_seq.sv
module phy_rst_seq
  import phy_rst_seq_pkg::*;
#(
  parameter int          DW        = 16,
  parameter int          MAX_POLLS = 10,
  parameter int          DELAY_CYC = 20,
  parameter logic [15:0] RST_REG   = 16'h7F3F,
  parameter logic [15:0] RST_VAL   = 16'h0001,
  parameter logic [15:0] STAT_REG  = 16'h2003,
  parameter logic [15:0] LOCK_MASK = 16'h0002
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic          cmd_valid_o,
  output logic [1:0]    cmd_op_o,
  output logic [DW-1:0] cmd_wdata_o,
  input  logic          rsp_valid_i,
  input  logic          rsp_err_i,
  input  logic [DW-1:0] rsp_rdata_i,
  output logic          done_o,
  output logic          pass_o,
  output logic [1:0]    err_o
);
  logic     dly_run, dly_expire, poll_clr, poll_inc, poll_last;
  cr_op_e   op;
  seq_err_e err;

  phy_rst_seq_timer #(.DELAY_CYC(DELAY_CYC)) u_timer (
    .clk_i, .rst_ni, .run_i(dly_run), .expire_o(dly_expire)
  );

  phy_rst_seq_pollcnt #(.MAX_POLLS(MAX_POLLS)) u_pollcnt (
    .clk_i, .rst_ni, .clr_i(poll_clr), .inc_i(poll_inc), .last_o(poll_last)
  );

  phy_rst_seq_fsm #(
    .DW(DW), .RST_REG(RST_REG), .RST_VAL(RST_VAL),
    .STAT_REG(STAT_REG), .LOCK_MASK(LOCK_MASK)
  ) u_fsm (
    .clk_i, .rst_ni, .start_i, .rsp_valid_i, .rsp_err_i, .rsp_rdata_i,
    .dly_expire_i(dly_expire), .poll_last_i(poll_last),
    .dly_run_o(dly_run), .poll_clr_o(poll_clr), .poll_inc_o(poll_inc),
    .busy_o, .cmd_valid_o, .cmd_op_o(op), .cmd_wdata_o,
    .done_o, .pass_o, .err_o(err)
  );

  assign cmd_op_o = op;
  assign err_o    = err;
endmodule

// File: rtl/phy_rst_seq_chk.sv
module phy_rst_seq_chk #(
  parameter int DW        = 16,
  parameter int MAX_POLLS = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          cmd_valid_o,
  input logic [1:0]    cmd_op_o,
  input logic [DW-1:0] cmd_wdata_o,
  input logic          rsp_valid_i,
  input logic          rsp_err_i,
  input logic          done_o,
  input logic          pass_o,
  input logic [1:0]    err_o
);
  localparam int CW = $clog2(MAX_POLLS + 2);

  logic [CW-1:0] rd_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_cnt_q <= '0;
    else if (!busy_o && start_i) rd_cnt_q <= '0;
    else if (cmd_valid_o && rsp_valid_i && cmd_op_o == 2'd2 && rd_cnt_q <= CW'(MAX_POLLS))
      rd_cnt_q <= rd_cnt_q + 1'b1;
  end

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_cmd_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && !rsp_valid_i |=> cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_wdata_o));

  assert_bus_err_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o && rsp_valid_i && rsp_err_i |=> done_o && err_o == 2'd1 && !cmd_valid_o);

  assert_result_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (pass_o == (err_o == 2'd0)) && err_o != 2'd3);

  assert_poll_bound_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cnt_q <= CW'(MAX_POLLS));

  assert_busy_kept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !done_o && start_i |=> busy_o);
endmodule

bind phy_rst_seq phy_rst_seq_chk #(.DW(DW), .MAX_POLLS(MAX_POLLS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .busy_o(busy_o),
  .cmd_valid_o(cmd_valid_o), .cmd_op_o(cmd_op_o), .cmd_wdata_o(cmd_wdata_o),
  .rsp_valid_i(rsp_valid_i), .rsp_err_i(rsp_err_i), .done_o(done_o),
  .pass_o(pass_o), .err_o(err_o)
);

// File: tb/phy_rst_seq_tb.sv
`timescale 1ns/1ps
module phy_rst_seq_tb;
  localparam int MAXP = 10;
  localparam int DLY  = 20;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        busy_o, cmd_valid_o, done_o, pass_o;
  logic [1:0]  cmd_op_o, err_o;
  logic [15:0] cmd_wdata_o;
  logic        rsp_valid_i = 1'b0, rsp_err_i = 1'b0;
  logic [15:0] rsp_rdata_i = '0;

  int checks = 0, failures = 0;
  int lock_at = 0, err_at = -1;
  int n_cmds = 0, n_reads = 0, gap = 0, n_done = 0, seq_bad = 0, hold_bad = 0;

  always #2.5 clk_i = ~clk_i;

  phy_rst_seq #(.MAX_POLLS(MAXP), .DELAY_CYC(DLY)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // bus master + PHY model
  initial begin
    forever begin
      @(negedge clk_i);
      rsp_valid_i = 1'b0; rsp_err_i = 1'b0; rsp_rdata_i = '0;
      if (rst_ni && cmd_valid_o) begin
        automatic logic [1:0]  op = cmd_op_o;
        automatic logic [15:0] wd = cmd_wdata_o;
        automatic int          idx = n_cmds;
        automatic int          lat = $urandom_range(0, 2);
        logic [1:0]  exp_op;
        logic [15:0] exp_wd;
        repeat (lat) begin
          @(negedge clk_i);
          if (cmd_op_o !== op || cmd_wdata_o !== wd || !cmd_valid_o) hold_bad++;
        end
        if (idx == 0)          begin exp_op = 2'd0; exp_wd = 16'h7F3F; end
        else if (idx == 1)     begin exp_op = 2'd1; exp_wd = 16'h0001; end
        else if (idx % 2 == 0) begin exp_op = 2'd0; exp_wd = 16'h2003; end
        else                   begin exp_op = 2'd2; exp_wd = wd;       end
        if (op !== exp_op || wd !== exp_wd) seq_bad++;
        n_cmds++;
        rsp_valid_i = 1'b1;
        rsp_err_i   = (idx == err_at);
        if (op == 2'd2) begin
          n_reads++;
          rsp_rdata_i = 16'($urandom) & 16'hFFFD;
          if (lock_at != 0 && n_reads >= lock_at) rsp_rdata_i[1] = 1'b1;
        end
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni && busy_o && !cmd_valid_o && !done_o) gap++;
    if (rst_ni && done_o) n_done++;
  end

  function automatic void expect_run(input int l, input int e, output int x_err,
      output int x_pass, output int x_cmds, output int x_reads, output int x_gap);
    x_err = 2; x_pass = 0; x_cmds = 0; x_reads = 0; x_gap = 0;
    for (int i = 0; i < 2; i++) begin
      x_cmds++;
      if (e == i) begin x_err = 1; return; end
    end
    for (int p = 0; p < MAXP; p++) begin
      x_gap += DLY;
      x_cmds++;
      if (e == 2 + 2*p) begin x_err = 1; return; end
      x_cmds++; x_reads++;
      if (e == 3 + 2*p) begin x_err = 1; return; end
      if (l != 0 && x_reads >= l) begin x_err = 0; x_pass = 1; return; end
    end
  endfunction

  task automatic run(input int l, input int e, input bit mid_start);
    int x_err, x_pass, x_cmds, x_reads, x_gap;
    int waited;
    expect_run(l, e, x_err, x_pass, x_cmds, x_reads, x_gap);
    lock_at = l; err_at = e;
    n_cmds = 0; n_reads = 0; gap = 0; n_done = 0; seq_bad = 0; hold_bad = 0;
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0;
    chk(busy_o && !pass_o && err_o == 2'd0, "R8 clear on start", {30'd0, err_o}, 0);
    if (mid_start) begin
      repeat (4) @(negedge clk_i);
      start_i = 1'b1; @(negedge clk_i); start_i = 1'b0;
    end
    waited = 0;
    while (!done_o && waited < 5000) begin @(negedge clk_i); waited++; end
    chk(done_o == 1'b1, "R8 done reached", waited, 0);
    chk(err_o == 2'(x_err), "R5/R6/R7 err code", err_o, x_err);
    chk(pass_o == x_pass[0], "R5 pass", pass_o, x_pass);
    repeat (3) @(negedge clk_i);
    chk(n_done == 1, "R8/R9 single done pulse", n_done, 1);
    chk(err_o == 2'(x_err) && pass_o == x_pass[0], "R8 result held", err_o, x_err);
    chk(n_reads == x_reads, "R6 read count", n_reads, x_reads);
    chk(n_cmds == x_cmds, "R7/R9 command count", n_cmds, x_cmds);
    chk(gap == x_gap, "R3 delay cycles", gap, x_gap);
    chk(seq_bad == 0, "R1/R2/R4 command order", seq_bad, 0);
    chk(hold_bad == 0, "R10 command hold", hold_bad, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !cmd_valid_o && !done_o && !pass_o && err_o == 2'd0,
        "R11 reset state", {28'd0, busy_o, cmd_valid_o, err_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    run(1, -1, 1'b0);            // lock on first poll
    run(MAXP, -1, 1'b0);         // lock on last allowed poll
    run(MAXP + 1, -1, 1'b0);     // R6 timeout by one
    run(0, -1, 1'b0);            // never locks
    run(3, 0, 1'b0);             // R7 error on address of reset register
    run(3, 1, 1'b0);             // R7 error on reset write
    run(3, 2, 1'b0);             // R7 error on first status address
    run(0, 2 * MAXP + 1, 1'b0);  // R7 error on final read
    run(4, -1, 1'b1);            // R9 start while busy
    for (int i = 0; i < 25; i++) begin
      automatic int l = $urandom_range(0, MAXP + 2);
      automatic int e = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 2 * MAXP + 1) : -1;
      run(l, e, $urandom_range(0, 1) == 1 && e == -1);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    failures++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule